// File: doc/BRIEF.md
# Programmable IR Pulse-Timing Decoder

This block watches a demodulated infrared receiver line and turns the pulse/space train of a remote-control frame into a right-aligned data word of up to 64 bits. The line is first brought into the clock domain and its active level is chosen by a polarity control. Each symbol runs from the start of one active pulse to the start of the next. The block measures the pulse width and the full period of every symbol and matches them against programmable windows. There is one window for an optional leader symbol and four windows for data symbols.

A frame ends when the line has stayed inactive longer than a programmable free time. The frame is kept only if its bit count lies inside a programmable length window. A kept frame raises a sticky data-valid flag with the length and the data. The flag holds until it is cleared. All timing and control values arrive as plain inputs, so any register front end can drive them.

The state machine has six states. `ST_OFF` is the decoder disabled. `ST_SYNC` waits for an idle line. `ST_ARMED` waits for a frame's first pulse. `ST_LEAD` measures the leader. `ST_DATA` collects bits. `ST_CHECK` is one cycle that qualifies the length.

Its transitions are:
- OFF→SYNC when enabled.
- SYNC→ARMED on a long idle.
- ARMED→LEAD on a pulse start with the leader enabled, or ARMED→DATA without it.
- LEAD→DATA on a matching leader, LEAD→SYNC on a mismatch, and LEAD→ARMED on idle.
- DATA→SYNC on an unmatched symbol or an overflow, and DATA→CHECK on idle.
- CHECK→ARMED always.
- Any state→OFF when the enable is low.

Top module: `ir_pulse_decoder`

## Requirements
- R1: After reset `data_valid` is 0, and `data_len`, `data_lo` and `data_hi` are all zero.
- R2: With `ctl_leader_en`=1 a frame is decoded only after a leader symbol whose width and period both lie inside `lead_win`. The fields of `lead_win` are counted in units of 16 cycles. A first symbol that fails this check aborts the frame, and no data-valid results.
- R3: Every window word packs four 8-bit fields: [31:24] period max, [23:16] period min, [15:8] width max and [7:0] width min. Data window k sits at `sym_win[32k+31:32k]`. For data windows the period fields are in units of 2 cycles and the width fields are in single cycles. A symbol matching window k decodes to bit value k[0], so windows 0 and 2 give 0 and windows 1 and 3 give 1. When several windows match, the lowest index wins.
- R4: A data symbol that matches no window aborts the frame. The decoder then waits for an idle line, and the next well-formed frame decodes normally.
- R5: A frame ends once the line has been inactive for `free_time`×8 cycles (a value of 0 acts as 1). The trailing pulse before that idle gap carries no bit.
- R6: A frame is accepted only when its bit count n satisfies (`len_min` with bit 0 cleared) ≤ n ≤ min(`len_max` rounded up to even, 48). Any other frame is dropped without setting `data_valid`.
- R7: With `ctl_lsb_first`=0 the first received bit lands at bit n−1. With `ctl_lsb_first`=1 it lands at bit 0. The data is always right-aligned in {`data_hi`,`data_lo`}.
- R8: With `ctl_bit_inv`=1 every decoded bit is inverted before it is stored.
- R9: With `ctl_pol_inv`=0 a high `ir_in` is the active pulse level. With `ctl_pol_inv`=1 the low level is active, and decoding is otherwise identical.
- R10: `data_valid` stays set with `data_len` and the data unchanged until `clear_valid` is pulsed. A frame completing while it is set is discarded.
- R11: While `ctl_enable` is 0 no frame is decoded. After `ctl_enable` returns to 1 and the line has been idle, frames decode again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Demodulated receiver line (asynchronous) |
| clear_valid | input | 1 | One-cycle pulse clearing `data_valid` |
| ctl_enable | input | 1 | Decoder enable; 0 stops and resets the decoder |
| ctl_pol_inv | input | 1 | Selects low as the active pulse level |
| ctl_leader_en | input | 1 | Require a leader symbol |
| ctl_lsb_first | input | 1 | First received bit goes to bit 0 |
| ctl_bit_inv | input | 1 | Invert decoded bits |
| lead_win | input | 32 | Leader window fields, ×16 cycles |
| sym_win | input | 128 | Four data windows, period ×2, width ×1 |
| free_time | input | 8 | End-of-frame idle threshold, ×8 cycles |
| len_min | input | 5 | Minimum frame length |
| len_max | input | 6 | Maximum frame length |
| data_valid | output | 1 | Sticky frame-received flag |
| data_len | output | 7 | Bit count of held frame |
| data_lo | output | 32 | Data bits 31:0 |
| data_hi | output | 32 | Data bits 63:32 |

## Verification
A frame's results are due a few cycles after the line has sat idle for `free_time`×8 cycles past the trailing pulse. That delay is two synchroniser stages, one cycle in `ST_CHECK` and one capture edge. The bench therefore lets 150 idle cycles pass before it samples, which is well beyond the 80-cycle threshold it programs. The end-of-frame test samples twice: once 40 cycles after the trailing pulse, where nothing may be set yet, and again after the threshold has clearly passed. All sampling happens on the falling clock edge, half a cycle away from the edge where the design updates.

// File: rtl/ir_dec_pkg.sv
package ir_dec_pkg;
    localparam int WIN_W    = 8;
    localparam int WIN_BITS = 4 * WIN_W;
    localparam int DATA_W   = 64;
    localparam int LEN_W    = 7;
    localparam int LEN_CAP  = 48;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_SYNC,
        ST_ARMED,
        ST_LEAD,
        ST_DATA,
        ST_CHECK
    } dec_state_e;

    typedef struct packed {
        logic [WIN_W-1:0] pd_max;
        logic [WIN_W-1:0] pd_min;
        logic [WIN_W-1:0] w_max;
        logic [WIN_W-1:0] w_min;
    } sym_win_t;
endpackage

// File: rtl/ir_edge_meter.sv
module ir_edge_meter #(
    parameter int CW  = 16,
    parameter int FTW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_in,
    input  logic          pol_inv,
    input  logic [FTW-1:0] free_time,
    output logic          pulse_start,
    output logic [CW-1:0] period,
    output logic [CW-1:0] width,
    output logic          idle_long
);
    logic          sync_a, sync_b, prev_act;
    logic          act;
    logic          pulse_end;
    logic [CW-1:0] pd_cnt;
    logic [CW-1:0] idle_cnt;
    logic [CW-1:0] thr;

    assign act         = sync_b ^ pol_inv;
    assign pulse_start = act & ~prev_act;
    assign pulse_end   = ~act & prev_act;
    assign period      = pd_cnt;
    assign thr         = (free_time == '0) ? CW'(8) : CW'({free_time, 3'b000});
    assign idle_long   = ~act & (idle_cnt >= thr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a   <= 1'b0;
            sync_b   <= 1'b0;
            prev_act <= 1'b0;
            pd_cnt   <= '0;
            idle_cnt <= '0;
            width    <= '0;
        end else begin
            sync_a   <= line_in;
            sync_b   <= sync_a;
            prev_act <= act;
            if (pulse_start)
                pd_cnt <= CW'(1);
            else if (pd_cnt != '1)
                pd_cnt <= pd_cnt + 1'b1;
            if (pulse_end)
                width <= pd_cnt;
            if (act)
                idle_cnt <= '0;
            else if (idle_cnt != '1)
                idle_cnt <= idle_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ir_sym_window.sv
module ir_sym_window
    import ir_dec_pkg::*;
#(
    parameter int CW    = 16,
    parameter int PD_SH = 1,
    parameter int W_SH  = 0
) (
    input  sym_win_t      win,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] width,
    output logic          hit
);
    logic [CW-1:0] p_lo, p_hi, w_lo, w_hi;

    assign p_lo = CW'(win.pd_min) << PD_SH;
    assign p_hi = CW'(win.pd_max) << PD_SH;
    assign w_lo = CW'(win.w_min)  << W_SH;
    assign w_hi = CW'(win.w_max)  << W_SH;
    assign hit  = (period >= p_lo) && (period <= p_hi) &&
                  (width  >= w_lo) && (width  <= w_hi);
endmodule

// File: rtl/ir_pulse_decoder.sv
module ir_pulse_decoder
    import ir_dec_pkg::*;
#(
    parameter int CW   = 16,
    parameter int FTW  = 8,
    parameter int NSYM = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ir_in,
    input  logic                     clear_valid,
    input  logic                     ctl_enable,
    input  logic                     ctl_pol_inv,
    input  logic                     ctl_leader_en,
    input  logic                     ctl_lsb_first,
    input  logic                     ctl_bit_inv,
    input  logic [WIN_BITS-1:0]      lead_win,
    input  logic [NSYM*WIN_BITS-1:0] sym_win,
    input  logic [FTW-1:0]           free_time,
    input  logic [4:0]               len_min,
    input  logic [5:0]               len_max,
    output logic                     data_valid,
    output logic [LEN_W-1:0]         data_len,
    output logic [31:0]              data_lo,
    output logic [31:0]              data_hi
);
    localparam logic [LEN_W-1:0] FULL_CNT = LEN_W'(DATA_W);

    dec_state_e        state, nxt;
    logic              rise, idle_long;
    logic [CW-1:0]     period, width;
    logic              lead_hit;
    logic [NSYM-1:0]   win_hit;
    logic              sym_hit, sym_bit;
    logic [DATA_W-1:0] shreg, data_word;
    logic [LEN_W-1:0]  bit_cnt;
    logic [LEN_W-1:0]  lmin, lmax_r, lmax;
    logic              len_ok, take_bit, new_bit;

    ir_edge_meter #(.CW(CW), .FTW(FTW)) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (ir_in),
        .pol_inv    (ctl_pol_inv),
        .free_time  (free_time),
        .pulse_start(rise),
        .period     (period),
        .width      (width),
        .idle_long  (idle_long)
    );

    ir_sym_window #(.CW(CW), .PD_SH(4), .W_SH(4)) u_lead (
        .win   (sym_win_t'(lead_win)),
        .period(period),
        .width (width),
        .hit   (lead_hit)
    );

    for (genvar k = 0; k < NSYM; k++) begin : g_sym
        ir_sym_window #(.CW(CW), .PD_SH(1), .W_SH(0)) u_win (
            .win   (sym_win_t'(sym_win[k*WIN_BITS +: WIN_BITS])),
            .period(period),
            .width (width),
            .hit   (win_hit[k])
        );
    end

    // lowest-numbered matching window decides the bit
    always_comb begin
        sym_hit = 1'b0;
        sym_bit = 1'b0;
        for (int k = NSYM - 1; k >= 0; k--) begin
            if (win_hit[k]) begin
                sym_hit = 1'b1;
                sym_bit = ((k % 2) != 0);
            end
        end
    end

    assign lmin   = {2'b00, len_min[4:1], 1'b0};
    assign lmax_r = {1'b0, len_max} + {6'b0, len_max[0]};
    assign lmax   = (lmax_r > LEN_W'(LEN_CAP)) ? LEN_W'(LEN_CAP) : lmax_r;
    assign len_ok = (bit_cnt >= lmin) && (bit_cnt <= lmax);

    assign take_bit = (state == ST_DATA) && rise && sym_hit && (bit_cnt != FULL_CNT);
    assign new_bit  = sym_bit ^ ctl_bit_inv;

    always_comb begin
        nxt = state;
        if (!ctl_enable) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:   nxt = ST_SYNC;
                ST_SYNC:  if (idle_long) nxt = ST_ARMED;
                ST_ARMED: if (rise) nxt = ctl_leader_en ? ST_LEAD : ST_DATA;
                ST_LEAD: begin
                    if (rise)           nxt = lead_hit ? ST_DATA : ST_SYNC;
                    else if (idle_long) nxt = ST_ARMED;
                end
                ST_DATA: begin
                    if (rise) begin
                        if (!sym_hit || bit_cnt == FULL_CNT) nxt = ST_SYNC;
                    end else if (idle_long) begin
                        nxt = ST_CHECK;
                    end
                end
                ST_CHECK: nxt = ST_ARMED;
                default:  nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            bit_cnt    <= '0;
            data_valid <= 1'b0;
            data_len   <= '0;
            data_word  <= '0;
        end else begin
            if (state == ST_ARMED || state == ST_OFF) begin
                shreg   <= '0;
                bit_cnt <= '0;
            end else if (take_bit) begin
                if (ctl_lsb_first)
                    shreg[bit_cnt[5:0]] <= new_bit;
                else
                    shreg <= {shreg[DATA_W-2:0], new_bit};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (clear_valid)
                data_valid <= 1'b0;
            if (state == ST_CHECK && len_ok && !data_valid) begin
                data_valid <= 1'b1;
                data_len   <= bit_cnt;
                data_word  <= shreg;
            end
        end
    end

    assign data_lo = data_word[31:0];
    assign data_hi = data_word[63:32];

    // R11: a low enable forces the decoder off on the next edge
    a_r11_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_enable |=> state == ST_OFF);

    // R4: an unmatched data symbol aborts the frame
    a_r4_abort_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && rise && !sym_hit) |=> (state == ST_SYNC || state == ST_OFF));

    // R2: a failed leader sends the decoder back to idle hunting
    a_r2_bad_leader: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAD && rise && !lead_hit && ctl_enable) |=> state == ST_SYNC);

    // R10: held frame is stable until cleared
    a_r10_hold_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && !clear_valid) |=>
            (data_valid && $stable(data_lo) && $stable(data_hi) && $stable(data_len)));

    // R6: no accepted frame exceeds the length cap
    a_r6_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> data_len <= LEN_W'(LEN_CAP));

    // R5: length qualification only follows a long idle
    a_r5_check_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_CHECK |-> $past(idle_long));
endmodule

// File: tb/ir_pulse_decoder_tb.sv
module ir_pulse_decoder_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ir_in = 1'b0;
    logic         clear_valid = 1'b0;
    logic         ctl_enable = 1'b0;
    logic         ctl_pol_inv = 1'b0;
    logic         ctl_leader_en = 1'b1;
    logic         ctl_lsb_first = 1'b0;
    logic         ctl_bit_inv = 1'b0;
    logic [31:0]  lead_win;
    logic [127:0] sym_win;
    logic [7:0]   free_time = 8'd10;
    logic [4:0]   len_min = 5'd5;
    logic [5:0]   len_max = 6'd33;
    logic         data_valid;
    logic [6:0]   data_len;
    logic [31:0]  data_lo, data_hi;
    logic         tb_pol = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5ns clk = ~clk;

    ir_pulse_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .clear_valid(clear_valid),
        .ctl_enable(ctl_enable), .ctl_pol_inv(ctl_pol_inv),
        .ctl_leader_en(ctl_leader_en), .ctl_lsb_first(ctl_lsb_first),
        .ctl_bit_inv(ctl_bit_inv), .lead_win(lead_win), .sym_win(sym_win),
        .free_time(free_time), .len_min(len_min), .len_max(len_max),
        .data_valid(data_valid), .data_len(data_len),
        .data_lo(data_lo), .data_hi(data_hi)
    );

    typedef struct packed {
        logic [6:0]  n;
        logic [63:0] bits;
        logic        lsbf;
        logic        inv;
        logic        lead;
        logic        pol;
        logic        ok;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{7'd8,  64'hB2,          1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R7 msb-first
        '{7'd8,  64'hB2,          1'b1, 1'b0, 1'b1, 1'b0, 1'b1},  // R7 lsb-first
        '{7'd12, 64'hC3A,         1'b0, 1'b1, 1'b1, 1'b0, 1'b1},  // R8 invert
        '{7'd10, 64'h2D9,         1'b1, 1'b0, 1'b1, 1'b1, 1'b1},  // R9 polarity
        '{7'd16, 64'h5AF0,        1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R2 no leader
        '{7'd4,  64'h9,           1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R6 min rounds down
        '{7'd34, 64'h2_F00F_1234, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},  // R6 max rounds up
        '{7'd36, 64'hA_5555_0001, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}   // R6 too long
    };

    function automatic logic [63:0] expect_word(logic [63:0] bits, int n, bit lsbf, bit inv);
        logic [63:0] w = '0;
        for (int i = 0; i < n; i++) begin
            if (lsbf) w[i] = bits[i] ^ inv;
            else      w[n-1-i] = bits[i] ^ inv;
        end
        return w;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        ir_in = tb_pol;
        repeat (n) @(negedge clk);
    endtask

    task automatic sym(int w, int p);
        ir_in = ~tb_pol;
        repeat (w) @(negedge clk);
        ir_in = tb_pol;
        repeat (p - w) @(negedge clk);
    endtask

    task automatic send_frame(logic [63:0] bits, int n, bit lead, int tail);
        if (lead) sym(160, 224);
        for (int i = 0; i < n; i++) sym(10, bits[i] ? 40 : 20);
        ir_in = ~tb_pol;
        repeat (10) @(negedge clk);
        idle(tail);
    endtask

    task automatic clear();
        clear_valid = 1'b1;
        @(negedge clk);
        clear_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic fin();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #2ms;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            fin();
        end
    end

    initial begin
        lead_win = {8'd16, 8'd12, 8'd12, 8'd8};
        sym_win  = {8'd12, 8'd8, 8'd14, 8'd6,      // window 3, same as window 0
                    8'd40, 8'd30, 8'd35, 8'd25,    // window 2, long bit 0
                    8'd23, 8'd17, 8'd14, 8'd6,     // window 1, bit 1
                    8'd12, 8'd8, 8'd14, 8'd6};     // window 0, bit 0
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", {63'd0, data_valid}, 64'd0);
        check("R1 len", {57'd0, data_len}, 64'd0);
        check("R1 data", {data_hi, data_lo}, 64'd0);
        rst_n = 1'b1;
        ctl_enable = 1'b1;
        idle(200);

        for (int v = 0; v < 8; v++) begin
            tb_pol        = VECS[v].pol;
            ctl_pol_inv   = VECS[v].pol;
            ctl_lsb_first = VECS[v].lsbf;
            ctl_bit_inv   = VECS[v].inv;
            ctl_leader_en = VECS[v].lead;
            idle(200);
            clear();
            send_frame(VECS[v].bits, int'(VECS[v].n), VECS[v].lead, 150);
            check($sformatf("R6/R7 vec%0d valid", v), {63'd0, data_valid}, {63'd0, VECS[v].ok});
            if (VECS[v].ok) begin
                check($sformatf("R3 vec%0d len", v), {57'd0, data_len}, {57'd0, VECS[v].n});
                check($sformatf("R7/R8/R9 vec%0d data", v), {data_hi, data_lo},
                      expect_word(VECS[v].bits, int'(VECS[v].n), VECS[v].lsbf, VECS[v].inv));
            end
        end
        tb_pol = 1'b0; ctl_pol_inv = 1'b0; ctl_lsb_first = 1'b0;
        ctl_bit_inv = 1'b0; ctl_leader_en = 1'b1;
        idle(200);

        // R2: leader enabled but frame lacks a leader
        clear();
        send_frame(64'hFF, 8, 1'b0, 150);
        check("R2 missing leader", {63'd0, data_valid}, 64'd0);

        // R4: bad symbol mid-frame, then a good frame
        clear();
        sym(160, 224);
        sym(10, 40); sym(10, 20); sym(10, 40);
        sym(10, 60);
        send_frame(64'h1F, 5, 1'b0, 150);
        check("R4 aborted frame", {63'd0, data_valid}, 64'd0);
        send_frame(64'h3C, 6, 1'b1, 150);
        check("R4 recovery valid", {63'd0, data_valid}, 64'd1);
        check("R4 recovery data", {data_hi, data_lo}, expect_word(64'h3C, 6, 1'b0, 1'b0));

        // R3: window 2 decodes a zero; window 3 overlaps window 0, lower index wins
        clear();
        sym(160, 224);
        sym(30, 70); sym(10, 40); sym(10, 20); sym(10, 40);
        ir_in = 1'b1; repeat (10) @(negedge clk);
        idle(150);
        check("R3 window decode", {data_hi, data_lo}, 64'h5);

        // R5: nothing before the idle threshold, then the frame without the trailing pulse
        clear();
        send_frame(64'h2B, 6, 1'b1, 40);
        check("R5 early", {63'd0, data_valid}, 64'd0);
        idle(80);
        check("R5 ended", {63'd0, data_valid}, 64'd1);
        check("R5 length", {57'd0, data_len}, 64'd6);

        // R10: second frame while valid is discarded
        send_frame(64'h11, 8, 1'b1, 150);
        check("R10 held data", {data_hi, data_lo}, expect_word(64'h2B, 6, 1'b0, 1'b0));
        check("R10 held len", {57'd0, data_len}, 64'd6);
        clear();
        check("R10 cleared", {63'd0, data_valid}, 64'd0);

        // R6: length cap of 48 when len_max exceeds it
        len_max = 6'd63;
        send_frame(64'h3_0000_0000_0001, 50, 1'b1, 150);
        check("R6 over cap", {63'd0, data_valid}, 64'd0);
        send_frame(64'h8000_1234_5678, 48, 1'b1, 150);
        check("R6 at cap", {57'd0, data_len}, 64'd48);
        check("R6 at cap data", {data_hi, data_lo}, expect_word(64'h8000_1234_5678, 48, 1'b0, 1'b0));
        len_max = 6'd33;

        // R6: too short
        clear();
        send_frame(64'h2, 2, 1'b1, 150);
        check("R6 too short", {63'd0, data_valid}, 64'd0);

        // R11: disabled decoder ignores frames
        ctl_enable = 1'b0;
        send_frame(64'hAA, 8, 1'b1, 150);
        check("R11 disabled", {63'd0, data_valid}, 64'd0);
        ctl_enable = 1'b1;
        idle(200);
        send_frame(64'hAA, 8, 1'b1, 150);
        check("R11 re-enabled", {data_hi, data_lo}, expect_word(64'hAA, 8, 1'b0, 1'b0));

        fin();
    end
endmodule